// File: doc/BRIEF.md
# OTP Configuration Register Controller

This block sits between a serial command front end and a 46-bit array of one-time-programmable fuse cells. Writes land in a shadow register first. A program command then burns into the fuses only the shadow bits that are set, not yet blown and inside the user region. Each burned bit gets a zap strobe exactly one clock wide. A digital read returns the fuses ORed with the shadow. An analog readback sequence steps an index through every fuse position, one per clock, starting at the top bit, so that an external measurement can sample each cell.

The low twelve bits hold the user configuration fields, and the block decodes them continuously from the fuses ORed with the shadow. Bit 13 is a lock that guards the factory trim region. Bits 16 to 43 are factory trim. Bits 44 and 45 are reserved for fuse test and ESD protection. The block ignores every command until a separate enable pulse has armed it.

The sequencer has three states. `S_IDLE` accepts commands. `S_PROG` walks the index upward from 0 to 45 and returns to `S_IDLE` after index 45. `S_ANA` walks the index downward from 45 to 0 and returns to `S_IDLE` after index 0. An accepted program command takes `S_IDLE` to `S_PROG`, and an accepted analog command takes `S_IDLE` to `S_ANA`. Write and read commands complete without leaving `S_IDLE`.

Top module: `otp_cfg_ctrl`

## Requirements
- R1: After reset, busy_o, rd_valid_o, zap_o and ana_valid_o are low and the shadow register is all zero.
- R2: Until arm_i has been seen high at a clock edge, every command is ignored: no read pulse appears and the shadow stays unchanged.
- R3: Command code 5'b11111 (shadow write) always stores data bits 0 to 11. While fuse bit 13 is 0 it also stores bits 13 and 16 to 43. Shadow bits 12, 14, 15, 44 and 45 stay 0 whatever the data.
- R4: While fuse bit 13 is 1, a shadow write leaves shadow bits 13 and 16 to 43 unchanged.
- R5: Command code 5'b01111 (digital read) raises rd_valid_o for one cycle, in the cycle after the accepting edge, with rd_data_o equal to fuse_q_i ORed with the shadow, bit for bit.
- R6: Command code 5'b11001 (program) holds busy_o high for 46 cycles starting the cycle after the accepting edge. In the k-th of those cycles (k = 0..45), zap_idx_o equals k. zap_o is high for one cycle exactly when bit k was 1 in the shadow and 0 in the fuses at the accepting edge, and k is in the user region.
- R7: No fuse bit above 11 is ever zapped, neither the lock, the factory bits nor the reserved bits.
- R8: Command code 5'b01001 (analog readback) holds ana_valid_o high for 46 cycles starting the cycle after the accepting edge. ana_idx_o counts down from 45 to 0, and ana_bit_o equals fuse_q_i[ana_idx_o].
- R9: Any command presented while busy_o is high is ignored.
- R10: The field outputs track the fuses ORed with the shadow: hall_bias_o = bits 5:0, offset_sel_o = bit 6, gain_o = bits 8:7, cm_cos_o = bit 9, cm_sin_o = bit 10, invert_o = bit 11.
- R11: A command code other than the four listed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Fuse-access enable pulse from the normal-mode decoder |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 5 | Decoded extended command code |
| cmd_data_i | input | 46 | Data word carried with the command |
| fuse_q_i | input | 46 | Current state of the fuse cells |
| busy_o | output | 1 | A program or readback sequence is running |
| rd_valid_o | output | 1 | Digital read result valid |
| rd_data_o | output | 46 | Fuses ORed with the shadow |
| zap_o | output | 1 | One-clock burn strobe |
| zap_idx_o | output | 6 | Bit index being burned |
| ana_valid_o | output | 1 | Analog readback step valid |
| ana_idx_o | output | 6 | Fuse index presented for measurement |
| ana_bit_o | output | 1 | Digital value of the presented fuse |
| hall_bias_o | output | 6 | Sensor bias field |
| offset_sel_o | output | 1 | Output offset select |
| gain_o | output | 2 | Amplifier gain field |
| cm_cos_o | output | 1 | Common-mode output enable, cosine channel |
| cm_sin_o | output | 1 | Common-mode output enable, sine channel |
| invert_o | output | 1 | Channel inversion |

## Verification
The hardest condition to reach is a locked fuse array while the shadow holds factory bits. That state needs the lock fuse blown after a write, and then a second write carrying the opposite pattern. The stimulus gets there by loading the bench's fuse model directly with bit 13 set, both between directed writes and at random points in the run. The second hard case is a command that arrives in the middle of a sequence. For this, the bench injects a write and a read a few cycles into an analog walk, then reads the shadow back afterwards to show that neither command had any effect.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;

    localparam int OTP_W    = 46;
    localparam int IDX_W    = $clog2(OTP_W);
    localparam int USER_HI  = 11;
    localparam int LOCK_POS = 13;
    localparam int FACT_LO  = 16;
    localparam int TEST_LO  = 44;

    localparam logic [4:0] CMD_WR_SHADOW = 5'b11111;
    localparam logic [4:0] CMD_BURN      = 5'b11001;
    localparam logic [4:0] CMD_RD_DIG    = 5'b01111;
    localparam logic [4:0] CMD_RD_ANA    = 5'b01001;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PROG = 2'd1,
        S_ANA  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       invert;
        logic       cm_sin;
        logic       cm_cos;
        logic [1:0] gain;
        logic       offset_sel;
        logic [5:0] hall_bias;
    } user_fields_t;

    // bits a user may set in the shadow and burn
    function automatic logic [OTP_W-1:0] user_mask();
        logic [OTP_W-1:0] m;
        m = '0;
        for (int i = 0; i <= USER_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    // bits that the lock protects from shadow writes
    function automatic logic [OTP_W-1:0] guarded_mask();
        logic [OTP_W-1:0] m;
        m = '0;
        m[LOCK_POS] = 1'b1;
        for (int i = FACT_LO; i < TEST_LO; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/otp_shadow_reg.sv
module otp_shadow_reg
    import otp_cfg_pkg::*;
#(
    parameter int W = OTP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         lock_i,
    output logic [W-1:0] shadow_o
);

    localparam logic [W-1:0] OPEN_M  = W'(user_mask());
    localparam logic [W-1:0] GUARD_M = W'(guarded_mask());

    logic [W-1:0] shadow_q;
    logic [W-1:0] wmask;

    always_comb begin
        wmask = OPEN_M;
        if (!lock_i) wmask = wmask | GUARD_M;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow_q <= '0;
        else if (we_i) shadow_q <= (shadow_q & ~wmask) | (wdata_i & wmask);
    end

    assign shadow_o = shadow_q;

    AST_LOCK_HOLDS_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(shadow_q & GUARD_M)); // R4

endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
    import otp_cfg_pkg::*;
#(
    parameter int W  = OTP_W,
    parameter int XW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog_i,
    input  logic          start_ana_i,
    input  logic [W-1:0]  pend_i,
    input  logic [W-1:0]  fuse_i,
    output logic          busy_o,
    output logic          zap_o,
    output logic [XW-1:0] zap_idx_o,
    output logic          ana_valid_o,
    output logic [XW-1:0] ana_idx_o,
    output logic          ana_bit_o
);

    localparam logic [XW-1:0] IDX_TOP = XW'(W - 1);

    seq_state_t    state_q, state_d;
    logic [XW-1:0] idx_q, idx_d;
    logic [W-1:0]  pend_q;

    // next-state and index logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_prog_i) begin
                    state_d = S_PROG;
                    idx_d   = '0;
                end else if (start_ana_i) begin
                    state_d = S_ANA;
                    idx_d   = IDX_TOP;
                end
            end
            S_PROG: begin
                if (idx_q == IDX_TOP) state_d = S_IDLE;
                else                  idx_d   = idx_q + XW'(1);
            end
            S_ANA: begin
                if (idx_q == '0) state_d = S_IDLE;
                else             idx_d   = idx_q - XW'(1);
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == S_IDLE && start_prog_i) pend_q <= pend_i;
        end
    end

    // outputs
    always_comb begin
        busy_o      = 1'b0;
        zap_o       = 1'b0;
        ana_valid_o = 1'b0;
        zap_idx_o   = idx_q;
        ana_idx_o   = idx_q;
        ana_bit_o   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PROG: begin
                busy_o = 1'b1;
                zap_o  = pend_q[idx_q];
            end
            S_ANA: begin
                busy_o      = 1'b1;
                ana_valid_o = 1'b1;
                ana_bit_o   = fuse_i[idx_q];
            end
            default: ;
        endcase
    end

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog_i || start_ana_i) |-> state_q == S_IDLE); // R9
    AST_ZAP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        zap_o |=> (!zap_o || zap_idx_o == $past(zap_idx_o) + XW'(1))); // R6
    AST_ZAP_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        zap_o |-> zap_idx_o <= XW'(USER_HI)); // R7
    AST_ANA_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_valid_o) |-> ana_idx_o == IDX_TOP); // R8
    AST_ANA_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_valid_o && ana_idx_o != '0) |=> (ana_valid_o && ana_idx_o == $past(ana_idx_o) - XW'(1))); // R8

endmodule

// File: rtl/otp_field_decode.sv
module otp_field_decode
    import otp_cfg_pkg::*;
#(
    parameter int W = OTP_W
) (
    input  logic [W-1:0]   fuse_i,
    input  logic [W-1:0]   shadow_i,
    output user_fields_t   fields_o,
    output logic [W-1:0]   eff_o
);

    localparam int FW = $bits(user_fields_t);

    always_comb begin
        eff_o    = fuse_i | shadow_i;
        fields_o = user_fields_t'(eff_o[FW-1:0]);
    end

endmodule

// File: rtl/otp_cfg_ctrl.sv
module otp_cfg_ctrl
    import otp_cfg_pkg::*;
#(
    parameter int W  = OTP_W,
    parameter int XW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          cmd_valid_i,
    input  logic [4:0]    cmd_code_i,
    input  logic [W-1:0]  cmd_data_i,
    input  logic [W-1:0]  fuse_q_i,
    output logic          busy_o,
    output logic          rd_valid_o,
    output logic [W-1:0]  rd_data_o,
    output logic          zap_o,
    output logic [XW-1:0] zap_idx_o,
    output logic          ana_valid_o,
    output logic [XW-1:0] ana_idx_o,
    output logic          ana_bit_o,
    output logic [5:0]    hall_bias_o,
    output logic          offset_sel_o,
    output logic [1:0]    gain_o,
    output logic          cm_cos_o,
    output logic          cm_sin_o,
    output logic          invert_o
);

    localparam logic [W-1:0] BURN_M = W'(user_mask());

    logic         armed_q;
    logic         accept;
    logic         do_wr, do_prog, do_ana, do_rd;
    logic [W-1:0] shadow;
    logic [W-1:0] eff;
    logic [W-1:0] pend;
    user_fields_t fields;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (arm_i) armed_q <= 1'b1;
    end

    assign accept = cmd_valid_i && armed_q && !busy_o;

    always_comb begin
        do_wr   = 1'b0;
        do_prog = 1'b0;
        do_ana  = 1'b0;
        do_rd   = 1'b0;
        if (accept) begin
            unique case (cmd_code_i)
                CMD_WR_SHADOW: do_wr   = 1'b1;
                CMD_BURN:      do_prog = 1'b1;
                CMD_RD_ANA:    do_ana  = 1'b1;
                CMD_RD_DIG:    do_rd   = 1'b1;
                default: ;
            endcase
        end
    end

    assign pend = shadow & ~fuse_q_i & BURN_M;

    otp_shadow_reg #(.W(W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (do_wr),
        .wdata_i  (cmd_data_i),
        .lock_i   (fuse_q_i[LOCK_POS]),
        .shadow_o (shadow)
    );

    otp_seq_fsm #(.W(W), .XW(XW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_prog_i (do_prog),
        .start_ana_i  (do_ana),
        .pend_i       (pend),
        .fuse_i       (fuse_q_i),
        .busy_o       (busy_o),
        .zap_o        (zap_o),
        .zap_idx_o    (zap_idx_o),
        .ana_valid_o  (ana_valid_o),
        .ana_idx_o    (ana_idx_o),
        .ana_bit_o    (ana_bit_o)
    );

    otp_field_decode #(.W(W)) u_dec (
        .fuse_i   (fuse_q_i),
        .shadow_i (shadow),
        .fields_o (fields),
        .eff_o    (eff)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= do_rd;
            if (do_rd) rd_data_o <= eff;
        end
    end

    assign hall_bias_o  = fields.hall_bias;
    assign offset_sel_o = fields.offset_sel;
    assign gain_o       = fields.gain;
    assign cm_cos_o     = fields.cm_cos;
    assign cm_sin_o     = fields.cm_sin;
    assign invert_o     = fields.invert;

    AST_READ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(armed_q)); // R2
    AST_READ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !$past(busy_o)); // R9

endmodule

// File: tb/tb_otp_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_otp_cfg_ctrl;

    localparam int W = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_code = '0;
    logic [W-1:0] cmd_data = '0;
    logic [W-1:0] fuse = '0;
    logic [W-1:0] fuse_next = '0;
    logic        fuse_load = 1'b0;
    logic        busy, rd_valid, zap, ana_valid, ana_bit;
    logic [W-1:0] rd_data;
    logic [5:0]  zap_idx, ana_idx, hall_bias;
    logic        offset_sel, cm_cos, cm_sin, invert;
    logic [1:0]  gain;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] exp_shadow = '0;
    logic [W-1:0] fuse_m = '0;

    always #10 clk = ~clk;

    otp_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .cmd_valid_i(cmd_valid),
        .cmd_code_i(cmd_code), .cmd_data_i(cmd_data), .fuse_q_i(fuse),
        .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .zap_o(zap), .zap_idx_o(zap_idx), .ana_valid_o(ana_valid),
        .ana_idx_o(ana_idx), .ana_bit_o(ana_bit), .hall_bias_o(hall_bias),
        .offset_sel_o(offset_sel), .gain_o(gain), .cm_cos_o(cm_cos),
        .cm_sin_o(cm_sin), .invert_o(invert)
    );

    // fuse cell model
    always @(posedge clk) begin
        if (fuse_load)          fuse <= fuse_next;
        else if (zap)           fuse[zap_idx] <= 1'b1;
    end

    function automatic logic [W-1:0] m_user();
        logic [W-1:0] m = '0;
        for (int i = 0; i < 12; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [W-1:0] m_write(input logic locked);
        logic [W-1:0] m = m_user();
        if (!locked) begin
            m[13] = 1'b1;
            for (int i = 16; i < 44; i++) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [W-1:0] rnd46();
        logic [63:0] r = {$urandom(), $urandom()};
        return r[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic send_cmd(input logic [4:0] code, input logic [W-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_fuse(input logic [W-1:0] v);
        @(negedge clk);
        fuse_next = v; fuse_load = 1'b1;
        @(negedge clk);
        fuse_load = 1'b0;
        fuse_m = v;
    endtask

    task automatic do_write(input logic [W-1:0] d);
        logic [W-1:0] m = m_write(fuse_m[13]);
        send_cmd(5'b11111, d);
        exp_shadow = (exp_shadow & ~m) | (d & m);
    endtask

    task automatic check_read(input string req);
        send_cmd(5'b01111, '0);
        chk(rd_valid == 1'b1, req, 64'(rd_valid), 64'd1);
        chk(rd_data == (fuse_m | exp_shadow), req, 64'(rd_data), 64'(fuse_m | exp_shadow));
        @(negedge clk);
        chk(rd_valid == 1'b0, {req, " pulse width"}, 64'(rd_valid), 64'd0);
    endtask

    task automatic check_fields();
        logic [W-1:0] e = fuse_m | exp_shadow;
        chk(hall_bias == e[5:0], "R10 hall", 64'(hall_bias), 64'(e[5:0]));
        chk(offset_sel == e[6], "R10 offset", 64'(offset_sel), 64'(e[6]));
        chk(gain == e[8:7], "R10 gain", 64'(gain), 64'(e[8:7]));
        chk(cm_cos == e[9], "R10 cm_cos", 64'(cm_cos), 64'(e[9]));
        chk(cm_sin == e[10], "R10 cm_sin", 64'(cm_sin), 64'(e[10]));
        chk(invert == e[11], "R10 invert", 64'(invert), 64'(e[11]));
    endtask

    task automatic run_prog();
        logic [W-1:0] pend = exp_shadow & ~fuse_m & m_user();
        send_cmd(5'b11001, '0);
        for (int k = 0; k < W; k++) begin
            chk(busy == 1'b1, "R6 busy", 64'(busy), 64'd1);
            chk(zap == pend[k], $sformatf("R6 zap at %0d", k), 64'(zap), 64'(pend[k]));
            if (zap) begin
                chk(zap_idx == 6'(k), "R6 zap index", 64'(zap_idx), 64'(k));
                chk(k < 12, "R7 zap outside user bits", 64'(k), 64'd11);
            end
            @(negedge clk);
        end
        chk(busy == 1'b0, "R6 busy end", 64'(busy), 64'd0);
        fuse_m = fuse_m | pend;
        chk(fuse == fuse_m, "R7 fuse result", 64'(fuse), 64'(fuse_m));
    endtask

    task automatic run_ana();
        send_cmd(5'b01001, '0);
        for (int k = 0; k < W; k++) begin
            chk(ana_valid && busy, "R8 valid", 64'(ana_valid), 64'd1);
            chk(ana_idx == 6'(W - 1 - k), "R8 index", 64'(ana_idx), 64'(W - 1 - k));
            chk(ana_bit == fuse_m[W-1-k], "R8 bit", 64'(ana_bit), 64'(fuse_m[W-1-k]));
            @(negedge clk);
        end
        chk(ana_valid == 1'b0 && busy == 1'b0, "R8 end", 64'(ana_valid), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !rd_valid && !zap && !ana_valid, "R1 idle outputs",
            {60'd0, busy, rd_valid, zap, ana_valid}, 64'd0);
        check_fields();

        // R2 commands before arming are ignored
        send_cmd(5'b11111, '1);
        send_cmd(5'b01111, '0);
        chk(rd_valid == 1'b0, "R2 read before arm", 64'(rd_valid), 64'd0);
        send_cmd(5'b01001, '0);
        chk(ana_valid == 1'b0, "R2 analog before arm", 64'(ana_valid), 64'd0);
        @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
        check_read("R2 shadow untouched");
        check_read("R1 shadow zero");

        // R11 unknown code ignored
        send_cmd(5'b10111, '1);
        send_cmd(5'b00000, '1);
        check_read("R11 unknown code");

        // R3 full write unlocked
        do_write('1);
        check_read("R3 write mask");
        check_fields();

        // R4 locked write
        set_fuse(46'h2000);
        do_write('0);
        check_read("R4 locked write");
        do_write(46'h0000_0000_0A5C);
        check_read("R4 locked user write");
        check_fields();

        // R6 / R7 program with some fuses already blown
        set_fuse(46'h0000_0000_0101);
        do_write(46'h3FFF_FFFF_F3A7);
        run_prog();
        check_read("R5 after program");
        check_fields();

        // R8 analog readback
        set_fuse(46'h2AAA_5555_F00F);
        run_ana();

        // R9 command while busy is ignored
        set_fuse('0);
        send_cmd(5'b01001, '0);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 5'b11111; cmd_data = '1;
        @(negedge clk);
        cmd_code = 5'b01111;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rd_valid == 1'b0, "R9 read while busy", 64'(rd_valid), 64'd0);
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
        chk(busy == 1'b0, "R9 sequence finished", 64'(busy), 64'd0);
        check_read("R9 write while busy");

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            int op = $urandom_range(0, 4);
            case (op)
                0: do_write(rnd46());
                1: check_read("R5 random read");
                2: run_prog();
                3: run_ana();
                default: begin
                    logic [W-1:0] f = rnd46() & rnd46();
                    f[13] = ($urandom_range(0, 2) == 0);
                    set_fuse(f);
                end
            endcase
            check_fields();
        end
        check_read("R3 final read");
        finish_run();
    end

endmodule